// File: doc/BRIEF.md
# Watchdog Timer with Protected Reset Control

This block is a watchdog timer. A free-running 13-bit divider produces a count tick at one of eight rates derived from the system clock. An 8-bit up-counter advances on each tick while the run bit is set. When the counter wraps from 0xFF to 0x00, a sticky overflow flag is set. If reset requests are enabled, the block also raises a reset request for a fixed number of system clocks. A kind output tells the system reset logic which type of reset is wanted.

Software reaches three byte-wide registers through a simple write strobe with a 2-bit address and 16-bit write data. The timer control register and the counter take the low data byte. The reset control register is guarded: a write only acts when the upper data byte carries one of two keys. One key acts on the flag-clear path. The other key writes the enable and kind bits.

During the pulse, the watchdog's own internal reset clears the timer control register and the counter. The reset control register keeps its value, so software can still see after the reset that the watchdog fired. The reset sequencer has two states:
- `S_WATCH`: normal counting.
- `S_RESET`: the request pulse is being driven.

It has two transitions:
- `S_WATCH` to `S_RESET`: an overflow occurs while the enable bit is set.
- `S_RESET` to `S_WATCH`: the pulse counter reaches `PULSE_LEN-1`.

Top module: `wdt_rstctl`

## Requirements
- R1: Timer control bits [2:0] select the tick rate: codes 0..7 give system clock divided by 2, 64, 128, 256, 512, 1024, 4096 and 8192. Code 0 is the reset value. The divider runs freely and is never cleared by a select change, so a new code applies from the next tick.
- R2: The counter (address 1) advances by exactly one per tick only while timer control bit 3 (run) is 1. Otherwise it holds.
- R3: A write to address 0 loads run and select from data bits [3:0]. A write to address 1 loads the counter from data bits [7:0], and that load takes precedence over a tick in the same cycle. Address 0 reads {4'b0, run, select}.
- R4: A tick at count 0xFF wraps the counter to 0x00 and sets the overflow flag (address 2, bit 7). With select code 0, starting from 0x00, this takes 512 clocks.
- R5: The flag is sticky. It clears only on an address-2 write with upper byte 0xA5 and data bit 7 equal to 0. With bit 7 equal to 1 the write leaves the flag set. An overflow in the same cycle as a clear leaves the flag set.
- R6: An address-2 write with upper byte 0x5A loads the enable bit from data bit 6 and the kind bit from data bit 5. A write with any other upper byte changes nothing.
- R7: Address 2 bits [4:0] always read 1. Address 3 reads 0x00.
- R8: An overflow while the enable bit is 1 makes `wdt_req` high from the next clock for exactly 512 clocks. An overflow with the enable bit at 0 raises no request.
- R9: `wdt_kind` always equals the kind bit (address 2, bit 5).
- R10: In the overflow cycle that starts a request, and for the whole pulse, run, select and counter are forced to 0 and writes to addresses 0 and 1 are ignored. The flag, enable and kind bits are kept.
- R11: `rst_n` low clears every register, so address 2 reads 0x1F. `standby` high re-initialises address 2 to 0x1F and leaves the timer running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| standby | input | 1 | Standby entry; re-initialises the reset control register |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 timer control, 1 counter, 2 reset control, 3 unused |
| bus_wdata | input | 16 | Write data; upper byte is the key for address 2 |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| wdt_req | output | 1 | Reset request pulse |
| wdt_kind | output | 1 | Requested reset type |

## Verification
The assertions check on every cycle that:
- the counter holds when it has no tick, load or internal reset;
- an internal reset leaves the timer cleared;
- the flag is set by an overflow and never drops without a keyed clear;
- the enable and kind bits move only on the 0x5A key;
- every rising edge of the request has an enabled overflow as its cause;
- every falling edge of the request comes at the end of the full pulse count.

Only the bench scenarios can show the following:
- the real overflow interval for each divider code and the 512-clock interval from 0x00;
- that bad keys and a clear with bit 7 set are ignored;
- that timer writes during the pulse are lost;
- that the flag and enable bit are still set once the pulse ends;
- how standby and `rst_n` differ in what they re-initialise.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int DIV_W = 13;
    localparam int CNT_W = 8;
    localparam int SEL_W = 3;

    localparam logic [1:0] A_TCTL  = 2'd0;
    localparam logic [1:0] A_COUNT = 2'd1;
    localparam logic [1:0] A_RCTL  = 2'd2;

    localparam logic [7:0] KEY_FLAG = 8'hA5;
    localparam logic [7:0] KEY_CTRL = 8'h5A;

    typedef enum logic {
        S_WATCH,
        S_RESET
    } wdt_state_e;

    // divider bit count for each select code: 2^n system clocks per tick
    function automatic logic [3:0] sel_shift(input logic [SEL_W-1:0] sel);
        logic [3:0] s;
        unique case (sel)
            3'd0: s = 4'd1;
            3'd1: s = 4'd6;
            3'd2: s = 4'd7;
            3'd3: s = 4'd8;
            3'd4: s = 4'd9;
            3'd5: s = 4'd10;
            3'd6: s = 4'd12;
            default: s = 4'd13;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] clk_sel,
    output logic             tick
);
    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W:0]   span;
    logic [DIV_W-1:0] mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_cnt <= '0;
        else        div_cnt <= div_cnt + 1'b1;
    end

    always_comb begin
        span = (DIV_W+1)'(1) << sel_shift(clk_sel);
        mask = DIV_W'(span - 1'b1);
        tick = &(div_cnt | ~mask);
    end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             hold,
    input  logic             req_en,
    input  logic             wr_ctl,
    input  logic             wr_cnt,
    input  logic [7:0]       wdata,
    output logic             run,
    output logic [SEL_W-1:0] clk_sel,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf_evt
);
    logic irst;

    assign ovf_evt = !hold && run && tick && (cnt == '1) && !wr_cnt;
    assign irst    = hold || (ovf_evt && req_en);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run     <= 1'b0;
            clk_sel <= '0;
            cnt     <= '0;
        end else if (irst) begin
            run     <= 1'b0;
            clk_sel <= '0;
            cnt     <= '0;
        end else begin
            if (wr_ctl) begin
                run     <= wdata[3];
                clk_sel <= wdata[SEL_W-1:0];
            end
            if (wr_cnt)          cnt <= wdata[CNT_W-1:0];
            else if (run && tick) cnt <= cnt + 1'b1;
        end
    end

    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !irst && !(run && tick)) |=> $stable(cnt));

    assert_irst_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irst |=> (cnt == '0 && !run && clk_sel == '0));
endmodule

// File: rtl/wdt_rctl.sv
module wdt_rctl
    import wdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       standby,
    input  logic       wr_rctl,
    input  logic [7:0] key,
    input  logic [2:0] wbits,
    input  logic       ovf_evt,
    output logic       ovf_flag,
    output logic       req_en,
    output logic       req_kind
);
    logic clr_hit, ctl_hit;

    assign clr_hit = wr_rctl && (key == KEY_FLAG) && !wbits[2];
    assign ctl_hit = wr_rctl && (key == KEY_CTRL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
            req_en   <= 1'b0;
            req_kind <= 1'b0;
        end else if (standby) begin
            ovf_flag <= 1'b0;
            req_en   <= 1'b0;
            req_kind <= 1'b0;
        end else begin
            if (ovf_evt)      ovf_flag <= 1'b1;
            else if (clr_hit) ovf_flag <= 1'b0;
            if (ctl_hit) begin
                req_en   <= wbits[1];
                req_kind <= wbits[0];
            end
        end
    end

    assert_flag_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_evt && !standby) |=> ovf_flag);

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !clr_hit && !standby) |=> ovf_flag);

    assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_hit && !standby) |=> $stable({req_en, req_kind}));

    assert_standby_init_R11: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> (!ovf_flag && !req_en && !req_kind));
endmodule

// File: rtl/wdt_reset_fsm.sv
module wdt_reset_fsm #(
    parameter int PULSE_LEN = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_evt,
    input  logic req_en,
    output logic in_reset,
    output logic wdt_req
);
    import wdt_pkg::*;
    localparam int PW = (PULSE_LEN > 1) ? $clog2(PULSE_LEN) : 1;
    localparam logic [PW-1:0] LAST = PW'(PULSE_LEN - 1);

    wdt_state_e state, state_nx;
    logic [PW-1:0] pcnt, pcnt_nx;

    always_comb begin
        state_nx = state;
        pcnt_nx  = pcnt;
        unique case (state)
            S_WATCH: if (ovf_evt && req_en) begin
                state_nx = S_RESET;
                pcnt_nx  = '0;
            end
            S_RESET: if (pcnt == LAST) begin
                state_nx = S_WATCH;
                pcnt_nx  = '0;
            end else begin
                pcnt_nx = pcnt + 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_WATCH;
            pcnt  <= '0;
        end else begin
            state <= state_nx;
            pcnt  <= pcnt_nx;
        end
    end

    always_comb begin
        in_reset = (state == S_RESET);
        wdt_req  = (state == S_RESET);
    end

    assert_req_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_req) |-> $past(ovf_evt && req_en));

    assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_req) |-> ($past(pcnt) == LAST));
endmodule

// File: rtl/wdt_rstctl.sv
module wdt_rstctl
    import wdt_pkg::*;
#(
    parameter int PULSE_LEN = 512
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        standby,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        wdt_req,
    output logic        wdt_kind
);
    logic             tick, in_reset, ovf_evt, run;
    logic             ovf_flag, req_en, req_kind;
    logic [SEL_W-1:0] clk_sel;
    logic [CNT_W-1:0] cnt;
    logic             wr_ctl, wr_cnt, wr_rctl;

    assign wr_ctl  = bus_wr && (bus_addr == A_TCTL);
    assign wr_cnt  = bus_wr && (bus_addr == A_COUNT);
    assign wr_rctl = bus_wr && (bus_addr == A_RCTL);

    wdt_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .tick(tick)
    );

    wdt_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .hold(in_reset),
        .req_en(req_en), .wr_ctl(wr_ctl), .wr_cnt(wr_cnt),
        .wdata(bus_wdata[7:0]), .run(run), .clk_sel(clk_sel),
        .cnt(cnt), .ovf_evt(ovf_evt)
    );

    wdt_rctl u_rctl (
        .clk(clk), .rst_n(rst_n), .standby(standby), .wr_rctl(wr_rctl),
        .key(bus_wdata[15:8]), .wbits(bus_wdata[7:5]), .ovf_evt(ovf_evt),
        .ovf_flag(ovf_flag), .req_en(req_en), .req_kind(req_kind)
    );

    wdt_reset_fsm #(.PULSE_LEN(PULSE_LEN)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ovf_evt(ovf_evt), .req_en(req_en),
        .in_reset(in_reset), .wdt_req(wdt_req)
    );

    assign wdt_kind = req_kind;

    always_comb begin
        unique case (bus_addr)
            A_TCTL:  bus_rdata = {4'b0000, run, clk_sel};
            A_COUNT: bus_rdata = cnt;
            A_RCTL:  bus_rdata = {ovf_flag, req_en, req_kind, 5'b11111};
            default: bus_rdata = 8'h00;
        endcase
    end
endmodule

// File: tb/wdt_rstctl_tb.sv
`timescale 1ns/1ps
module wdt_rstctl_tb;
    localparam int PULSE = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [7:0]  bus_rdata;
    logic        wdt_req, wdt_kind;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    wdt_rstctl #(.PULSE_LEN(PULSE)) u_dut (
        .clk(clk), .rst_n(rst_n), .standby(standby), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_req(wdt_req), .wdt_kind(wdt_kind)
    );

    // behavioural reference model
    int dv[8] = '{2, 64, 128, 256, 512, 1024, 4096, 8192};
    int m_div, m_sel, m_cnt, m_pc;
    bit m_run, m_flag, m_en, m_kind, m_req;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_div = 0; m_sel = 0; m_cnt = 0; m_pc = 0;
            m_run = 0; m_flag = 0; m_en = 0; m_kind = 0; m_req = 0;
        end else begin
            bit tk, ev, irst, wt, wc, wr;
            wt = bus_wr && bus_addr == 0;
            wc = bus_wr && bus_addr == 1;
            wr = bus_wr && bus_addr == 2;
            tk = (m_div % dv[m_sel]) == dv[m_sel] - 1;
            ev = !m_req && m_run && tk && m_cnt == 255 && !wc;
            irst = m_req || (ev && m_en);
            if (m_req) begin
                if (m_pc == PULSE - 1) begin m_req = 0; m_pc = 0; end
                else m_pc++;
            end else if (ev && m_en) begin
                m_req = 1; m_pc = 0;
            end
            if (irst) begin
                m_run = 0; m_sel = 0; m_cnt = 0;
            end else begin
                if (wc) m_cnt = bus_wdata[7:0];
                else if (m_run && tk) m_cnt = (m_cnt + 1) % 256;
                if (wt) begin m_run = bus_wdata[3]; m_sel = bus_wdata[2:0]; end
            end
            if (standby) begin
                m_flag = 0; m_en = 0; m_kind = 0;
            end else begin
                if (ev) m_flag = 1;
                else if (wr && bus_wdata[15:8] == 8'hA5 && !bus_wdata[7]) m_flag = 0;
                if (wr && bus_wdata[15:8] == 8'h5A) begin
                    m_en = bus_wdata[6]; m_kind = bus_wdata[5];
                end
            end
            m_div = (m_div + 1) % 8192;
        end
    end

    task automatic chk(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            case (bus_addr)
                2'd0: chk("R2", bus_rdata, {4'b0, m_run, 3'(m_sel)}, "timer control");
                2'd1: chk("R4", bus_rdata, m_cnt, "counter");
                2'd2: chk("R5", bus_rdata, {m_flag, m_en, m_kind, 5'h1F}, "reset control");
                default: chk("R7", bus_rdata, 0, "unused address");
            endcase
            chk("R8", wdt_req, m_req, "request");
            chk("R9", wdt_kind, m_kind, "kind");
        end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(posedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        v = bus_rdata;
    endtask

    task automatic wait_flag(input int limit, output int n);
        n = 0;
        bus_addr = 2'd2;
        do begin
            @(negedge clk);
            n++;
        end while (!bus_rdata[7] && n < limit);
    endtask

    task automatic report();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [7:0] v;
        int n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R11 reset state
        rd(0, v); chk("R11", v, 8'h00, "reset control");
        rd(1, v); chk("R11", v, 8'h00, "reset counter");
        rd(2, v); chk("R11", v, 8'h1F, "reset rctl");
        rd(3, v); chk("R7", v, 8'h00, "addr3");

        // R3 load and readback
        wr(0, 16'h0005); rd(0, v); chk("R3", v, 8'h05, "tctl load");
        wr(1, 16'h007C); rd(1, v); chk("R3", v, 8'h7C, "count load");
        repeat (20) @(posedge clk);
        rd(1, v); chk("R2", v, 8'h7C, "hold while stopped");

        // R4 interval from 0x00 at divide 2
        wr(0, 16'h0000); wr(1, 16'h0000); wr(0, 16'h0008);
        wait_flag(2000, n);
        chk("R4", (n >= 510 && n <= 514), 1, "interval 512");
        rd(0, v); chk("R8", wdt_req, 0, "no request when disabled");

        // R5 clear path
        wr(2, 16'hA5FF); rd(2, v); chk("R5", v[7], 1, "bit7=1 no clear");
        wr(2, 16'h1200); rd(2, v); chk("R5", v[7], 1, "bad key no clear");
        wr(0, 16'h0000);
        wr(2, 16'hA500); rd(2, v); chk("R5", v[7], 0, "keyed clear");

        // R6 / R7 / R9 control bits
        wr(2, 16'h3360); rd(2, v); chk("R6", v, 8'h1F, "bad key ignored");
        wr(2, 16'h5A20); rd(2, v); chk("R6", v, 8'h3F, "kind set");
        chk("R9", wdt_kind, 1, "kind output");
        wr(2, 16'h5A00); rd(2, v); chk("R7", v[4:0], 5'h1F, "reserved ones");
        chk("R9", wdt_kind, 0, "kind output clear");

        // R1 every select code from 0xFF
        for (int s = 0; s < 8; s++) begin
            wr(0, 16'(s)); wr(2, 16'hA500); wr(1, 16'h00FF);
            wr(0, 16'(8 | s));
            wait_flag(9000, n);
            chk("R1", (n >= 1 && n <= dv[s] + 1), 1, $sformatf("select %0d", s));
        end

        // R8 pulse length with enable
        wr(0, 16'h0000); wr(2, 16'hA500); wr(2, 16'h5A40);
        wr(1, 16'h00FF); wr(0, 16'h0008);
        wait_flag(100, n);
        chk("R8", wdt_req, 1, "request raised");
        n = 0;
        while (wdt_req && n < 2000) begin @(negedge clk); n++; end
        chk("R8", n, PULSE, "pulse length");
        rd(2, v); chk("R10", v, 8'hDF, "rctl kept after pulse");
        rd(0, v); chk("R10", v, 8'h00, "tctl cleared");

        // R10 writes ignored during pulse
        wr(2, 16'hA500); wr(1, 16'h00FF); wr(0, 16'h0008);
        wait_flag(100, n);
        wr(0, 16'h000F); rd(0, v); chk("R10", v, 8'h00, "tctl write ignored");
        wr(1, 16'h0033); rd(1, v); chk("R10", v, 8'h00, "count write ignored");
        while (wdt_req) @(negedge clk);

        // R11 standby vs external reset
        wr(2, 16'h5A00); wr(0, 16'h0008);
        @(posedge clk); #1 standby = 1;
        @(posedge clk); #1 standby = 0;
        rd(2, v); chk("R11", v, 8'h1F, "standby init");
        rd(0, v); chk("R11", v, 8'h08, "standby leaves timer");
        @(posedge clk); #1 rst_n = 0;
        @(posedge clk); #1 rst_n = 1;
        rd(0, v); chk("R11", v, 8'h00, "reset clears timer");

        repeat (5) @(posedge clk);
        report();
    end
endmodule